// File: doc/BRIEF.md
# Channel-Addressed Mailbox Dispatcher

This block takes 32-bit mailbox words written by a host and steers each one to one of several child channels. The low four bits of the word name the target channel, and the whole word, routing bits included, goes to the child unchanged. If the child is idle, the word goes straight to it on a shared data bus with a one-hot strobe. If the child reports busy, the word waits in an outbound FIFO. The FIFO forwards its oldest word once that word's child drops busy.

In the other direction, each child raises an available flag when it holds a response word. Every cycle the block acknowledges the lowest-numbered available channel and moves that word into a shared inbound FIFO. The host drains the inbound FIFO through a pop port. Words aimed at channels that do not exist, sends that meet a full outbound FIFO, and available flags that carry the invalid marker are all discarded, and each one raises a single-cycle error pulse.

Top module: `mbx_dispatch`

## Requirements
- R1: A write is treated as a send only when its byte offset is 0xA0, 0xA4, 0xA8 or 0xAC. Writes to any other offset change no output and no queue level.
- R2: The target channel is bits [3:0] of the sent word. For an idle, existing channel, the cycle after the write `ch_wstb` is one-hot on that channel (bit n for channel n) and `ch_wdata` carries the unchanged 32-bit word.
- R3: A sent word whose channel number is NUM_CH or greater produces no strobe. It is not queued, and `err` is high the next cycle.
- R4: A sent word whose child has `ch_busy` high produces no strobe, and the outbound queue level rises by one.
- R5: A send that arrives while the outbound queue is full is dropped with `err`. This holds even when the addressed child is idle, and the queue level does not change.
- R6: When the child of the oldest queued word is not busy, that word is strobed to it, one word per cycle, in FIFO order. A direct send in the same cycle takes the bus first, and the queued word follows one cycle later.
- R7: Reading offset 0xB8 returns the outbound status: bit 31 is full, bit 30 is empty, bits [7:0] are the queue level, and all other bits are 0. Any other read offset returns 0.
- R8: Each cycle in which the inbound queue is not full, `ch_rack` is one-hot on the lowest channel whose `ch_avail` is set, and that channel's `ch_rdata` slice (bits [32n+31:32n]) enters the inbound queue. The queue is popped in arrival order through `in_pop`/`in_data`.
- R9: While the inbound queue is full, `ch_rack` stays zero and nothing is captured.
- R10: An acknowledged response equal to INVALID_WORD (default 0x0000000F) is not stored, and `err` is high the next cycle.
- R11: After reset, `ch_wstb`, `ch_rack` and `err` are zero and both queues are empty. `err` is a single-cycle pulse per offending cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_addr | input | 8 | Host write byte offset |
| host_wr_data | input | 32 | Host write word |
| host_rd_addr | input | 8 | Host read byte offset |
| host_rd_data | output | 32 | Host read data (combinational) |
| in_pop | input | 1 | Pop the oldest inbound response |
| in_data | output | 32 | Oldest inbound response |
| in_empty | output | 1 | Inbound queue empty |
| ch_wdata | output | 32 | Word presented to the children |
| ch_wstb | output | NUM_CH | One-hot write strobe per child |
| ch_busy | input | NUM_CH | Child busy flags |
| ch_avail | input | NUM_CH | Child response-available flags |
| ch_rdata | input | 32*NUM_CH | Child response words, channel n in slice n |
| ch_rack | output | NUM_CH | One-hot response acknowledge (combinational) |
| err | output | 1 | Error pulse |

## Verification
A send's strobe, its error pulse and its change to the queue level all appear one cycle after the write edge. The bench drives each write at a falling edge and reads the results at the next falling edge. A released busy flag yields the first drained strobe one cycle later and the next words on consecutive cycles, so each drained word is checked on its own falling edge. `ch_rack` is combinational and is sampled shortly after each falling edge. The matching capture lands at the following rising edge, so the model child clears its flag at the falling edge after that, and the popped order is compared with the ascending channel order worked out in the bench.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int WORD_W    = 32;
    localparam int CHAN_BITS = 4;
    localparam int OFF_W     = 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [OFF_W-1:0]  off_t;

    localparam off_t STATUS_OFF = 8'hB8;
    localparam logic [3:0] SEND_PAGE = 4'hA;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [W-1:0]                 data_i,
    input  logic                         pop_i,
    output logic [W-1:0]                 data_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push_i && (st_q.cnt != CNT_W'(DEPTH));
        do_pop  = pop_i && (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wp] = data_i;
            st_d.wp           = bump(st_q.wp);
        end
        if (do_pop) begin
            st_d.rp = bump(st_q.rp);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.mem[st_q.rp];
    assign count_o = st_q.cnt;
endmodule

// File: rtl/mbx_low_pick.sv
module mbx_low_pick #(
    parameter int N = 9
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);
    // Isolate the lowest set bit: the request ANDed with its two's complement.
    assign grant_o = req_i & (~req_i + N'(1));
    assign any_o   = |req_i;
endmodule

// File: rtl/mbx_dispatch.sv
module mbx_dispatch
    import mbx_pkg::*;
#(
    parameter int    NUM_CH       = 9,
    parameter int    OUT_DEPTH    = 4,
    parameter int    IN_DEPTH     = 4,
    parameter word_t INVALID_WORD = 32'h0000_000F
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr_en,
    input  logic [7:0]               host_wr_addr,
    input  logic [31:0]              host_wr_data,
    input  logic [7:0]               host_rd_addr,
    output logic [31:0]              host_rd_data,
    input  logic                     in_pop,
    output logic [31:0]              in_data,
    output logic                     in_empty,
    output logic [31:0]              ch_wdata,
    output logic [NUM_CH-1:0]        ch_wstb,
    input  logic [NUM_CH-1:0]        ch_busy,
    input  logic [NUM_CH-1:0]        ch_avail,
    input  logic [NUM_CH*32-1:0]     ch_rdata,
    output logic [NUM_CH-1:0]        ch_rack,
    output logic                     err
);
    localparam int OB_CNT_W = $clog2(OUT_DEPTH+1);
    localparam int IB_CNT_W = $clog2(IN_DEPTH+1);

    typedef struct packed {
        logic [NUM_CH-1:0] wstb;
        word_t             wdata;
        logic              err;
    } disp_st_t;

    disp_st_t st_d, st_q;

    word_t                ob_head;
    logic [OB_CNT_W-1:0]  ob_cnt;
    logic                 ob_full, ob_empty;
    logic [IB_CNT_W-1:0]  in_cnt;
    logic                 in_full;
    logic [NUM_CH-1:0]    grant;
    logic                 grant_any;

    logic                 send_hit, ch_ok, wr_busy, head_busy;
    logic                 direct_go, ob_push, drain_go, take, in_push;
    logic [CHAN_BITS-1:0] wr_ch, head_ch;
    word_t                rsp_word;

    assign ob_full  = (ob_cnt == OB_CNT_W'(OUT_DEPTH));
    assign ob_empty = (ob_cnt == '0);
    assign in_full  = (in_cnt == IB_CNT_W'(IN_DEPTH));
    assign in_empty = (in_cnt == '0);

    mbx_low_pick #(.N(NUM_CH)) i_pick (
        .req_i   (ch_avail),
        .grant_o (grant),
        .any_o   (grant_any)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wstb = '0;
        st_d.err  = 1'b0;

        wr_ch    = host_wr_data[CHAN_BITS-1:0];
        head_ch  = ob_head[CHAN_BITS-1:0];
        send_hit = host_wr_en && (host_wr_addr[7:4] == SEND_PAGE)
                   && (host_wr_addr[1:0] == 2'b00);
        ch_ok    = (int'(wr_ch) < NUM_CH);

        wr_busy   = 1'b0;
        head_busy = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (wr_ch == CHAN_BITS'(i))   wr_busy   = ch_busy[i];
            if (head_ch == CHAN_BITS'(i)) head_busy = ch_busy[i];
        end

        direct_go = send_hit && !ob_full && ch_ok && !wr_busy;
        ob_push   = send_hit && !ob_full && ch_ok && wr_busy;
        drain_go  = !ob_empty && !head_busy && !direct_go;

        if (direct_go) begin
            st_d.wdata = host_wr_data;
            for (int i = 0; i < NUM_CH; i++) st_d.wstb[i] = (wr_ch == CHAN_BITS'(i));
        end else if (drain_go) begin
            st_d.wdata = ob_head;
            for (int i = 0; i < NUM_CH; i++) st_d.wstb[i] = (head_ch == CHAN_BITS'(i));
        end

        rsp_word = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (grant[i]) rsp_word = rsp_word | ch_rdata[i*WORD_W +: WORD_W];
        end
        take    = grant_any && !in_full;
        in_push = take && (rsp_word != INVALID_WORD);

        st_d.err = (send_hit && (ob_full || !ch_ok))
                 || (take && (rsp_word == INVALID_WORD));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    mbx_fifo #(.DEPTH(OUT_DEPTH), .W(WORD_W)) i_out_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (ob_push),
        .data_i  (host_wr_data),
        .pop_i   (drain_go),
        .data_o  (ob_head),
        .count_o (ob_cnt)
    );

    mbx_fifo #(.DEPTH(IN_DEPTH), .W(WORD_W)) i_in_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (in_push),
        .data_i  (rsp_word),
        .pop_i   (in_pop),
        .data_o  (in_data),
        .count_o (in_cnt)
    );

    assign ch_rack      = take ? grant : '0;
    assign ch_wstb      = st_q.wstb;
    assign ch_wdata     = st_q.wdata;
    assign err          = st_q.err;
    assign host_rd_data = (host_rd_addr == STATUS_OFF)
                        ? {ob_full, ob_empty, 22'd0, 8'(ob_cnt)} : 32'd0;
endmodule

// File: rtl/mbx_dispatch_chk.sv
module mbx_dispatch_chk
    import mbx_pkg::*;
#(
    parameter int    NUM_CH       = 9,
    parameter int    OUT_DEPTH    = 4,
    parameter int    OB_CNT_W     = 3,
    parameter word_t INVALID_WORD = 32'h0000_000F
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  host_wr_en,
    input logic [7:0]            host_wr_addr,
    input logic [31:0]           host_wr_data,
    input logic [NUM_CH-1:0]     ch_wstb,
    input logic [NUM_CH-1:0]     ch_avail,
    input logic [NUM_CH*32-1:0]  ch_rdata,
    input logic [NUM_CH-1:0]     ch_rack,
    input logic                  err,
    input logic                  ob_full,
    input logic [OB_CNT_W-1:0]   ob_cnt,
    input logic                  in_full
);
    logic  is_send;
    word_t acked_word;

    assign is_send = host_wr_en && (host_wr_addr[7:4] == 4'hA) && (host_wr_addr[1:0] == 2'b00);

    always_comb begin
        acked_word = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_rack[i]) acked_word = acked_word | ch_rdata[i*32 +: 32];
        end
    end

    // R2
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_wstb));

    // R8
    rack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_rack));

    // R8
    rack_needs_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_rack & ~ch_avail) == '0);

    // R8
    rack_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_rack != '0) |-> (((ch_rack - NUM_CH'(1)) & ch_avail) == '0));

    // R9
    rack_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_full |-> (ch_rack == '0));

    // R3
    bad_chan_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_send && (int'(host_wr_data[3:0]) >= NUM_CH)) |=> err);

    // R5
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_send && ob_full) |=> (err && (ob_cnt <= $past(ob_cnt))));

    // R4
    ob_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ob_cnt) <= OUT_DEPTH);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_send && (ob_cnt == '0)) |=> (ch_wstb == '0));

    // R10
    invalid_rsp_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_rack != '0) && (acked_word == INVALID_WORD)) |=> err);
endmodule

bind mbx_dispatch mbx_dispatch_chk #(
    .NUM_CH       (NUM_CH),
    .OUT_DEPTH    (OUT_DEPTH),
    .OB_CNT_W     (OB_CNT_W),
    .INVALID_WORD (INVALID_WORD)
) i_mbx_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_en   (host_wr_en),
    .host_wr_addr (host_wr_addr),
    .host_wr_data (host_wr_data),
    .ch_wstb      (ch_wstb),
    .ch_avail     (ch_avail),
    .ch_rdata     (ch_rdata),
    .ch_rack      (ch_rack),
    .err          (err),
    .ob_full      (ob_full),
    .ob_cnt       (ob_cnt),
    .in_full      (in_full)
);

// File: tb/test_mbx_dispatch.sv
`timescale 1ns/1ps
module test_mbx_dispatch;
    localparam int N  = 5;
    localparam int OD = 4;
    localparam int ID = 4;
    localparam logic [31:0] INV = 32'h0000_000F;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            host_wr_en = 1'b0;
    logic [7:0]      host_wr_addr = 8'h00;
    logic [31:0]     host_wr_data = 32'h0;
    logic [7:0]      host_rd_addr = 8'hB8;
    logic [31:0]     host_rd_data;
    logic            in_pop = 1'b0;
    logic [31:0]     in_data;
    logic            in_empty;
    logic [31:0]     ch_wdata;
    logic [N-1:0]    ch_wstb;
    logic [N-1:0]    ch_busy = '0;
    logic [N-1:0]    ch_avail = '0;
    logic [N*32-1:0] ch_rdata = '0;
    logic [N-1:0]    ch_rack;
    logic            err;

    int checks = 0;
    int fails  = 0;
    logic [N-1:0] pend = '0;
    logic [31:0]  qw [4];

    always #2.5 clk = ~clk;

    mbx_dispatch #(.NUM_CH(N), .OUT_DEPTH(OD), .IN_DEPTH(ID), .INVALID_WORD(INV)) i_mbx_dispatch (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
        .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
        .in_pop(in_pop), .in_data(in_data), .in_empty(in_empty),
        .ch_wdata(ch_wdata), .ch_wstb(ch_wstb), .ch_busy(ch_busy),
        .ch_avail(ch_avail), .ch_rdata(ch_rdata), .ch_rack(ch_rack), .err(err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_addr = a; host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
        #0.5;
    endtask

    // model child: clear a flag the falling edge after its acknowledge was seen
    task automatic resp_cycle();
        @(negedge clk);
        ch_avail = ch_avail & ~pend;
        #1;
        pend = ch_rack;
    endtask

    function automatic logic [31:0] rsp_of(input int c);
        return 32'hD000_0010 + (c << 8);
    endfunction

    initial begin
        #500000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R11 reset state, R7 status encoding
        check("R11 strobe", 32'(ch_wstb), 32'h0);
        check("R11 err", 32'(err), 32'h0);
        check("R11 rack", 32'(ch_rack), 32'h0);
        check("R11 in_empty", 32'(in_empty), 32'h1);
        check("R7 status reset", host_rd_data, 32'h4000_0000);

        // R2 / R3 / R1: sweep every channel code across the four send offsets
        for (int c = 0; c < 16; c++) begin
            logic [31:0] w;
            w = 32'hC0DE_0000 | 32'(c << 8) | 32'(c);
            host_write(8'hA0 + 8'(4 * (c % 4)), w);
            if (c < N) begin
                check("R2 strobe", 32'(ch_wstb), 32'(1 << c));
                check("R2 data", ch_wdata, w);
                check("R2 no err", 32'(err), 32'h0);
            end else begin
                check("R3 strobe", 32'(ch_wstb), 32'h0);
                check("R3 err", 32'(err), 32'h1);
                @(negedge clk); #0.5;
                check("R11 err pulse", 32'(err), 32'h0);
            end
            check("R3 nothing queued", host_rd_data, 32'h4000_0000);
        end

        // R1: other offsets have no effect
        foreach (qw[k]) qw[k] = 32'h0;
        for (int k = 0; k < 6; k++) begin
            logic [7:0] a;
            case (k)
                0: a = 8'h90; 1: a = 8'h94; 2: a = 8'h9C;
                3: a = 8'hB0; 4: a = 8'hA2; default: a = 8'hB8;
            endcase
            host_write(a, 32'h1234_5601);
            check("R1 strobe", 32'(ch_wstb), 32'h0);
            check("R1 err", 32'(err), 32'h0);
            check("R1 status", host_rd_data, 32'h4000_0000);
        end

        // R4: busy child queues words
        ch_busy = 5'b00100;
        for (int k = 0; k < 4; k++) begin
            qw[k] = 32'hA000_0002 + 32'(k << 4);
            host_write(8'hA8, qw[k]);
            check("R4 strobe", 32'(ch_wstb), 32'h0);
            check("R4 err", 32'(err), 32'h0);
            check("R4 R7 level", host_rd_data, (k == 3) ? 32'h8000_0004 : 32'(k + 1));
        end
        host_rd_addr = 8'h98; #0.5;
        check("R7 other read", host_rd_data, 32'h0);
        host_rd_addr = 8'hB8; #0.5;

        // R5: full queue drops, even for an idle child
        host_write(8'hA0, 32'hBAD0_0002);
        check("R5 err busy", 32'(err), 32'h1);
        check("R5 level", host_rd_data, 32'h8000_0004);
        host_write(8'hA4, 32'hBAD0_0001);
        check("R5 err idle", 32'(err), 32'h1);
        check("R5 strobe idle", 32'(ch_wstb), 32'h0);
        check("R5 level idle", host_rd_data, 32'h8000_0004);

        // R6: release busy, words drain in order, one per cycle
        ch_busy = '0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #0.5;
            check("R6 drain strobe", 32'(ch_wstb), 32'h4);
            check("R6 drain data", ch_wdata, qw[k]);
            check("R6 level", host_rd_data, (k == 3) ? 32'h4000_0000 : 32'(3 - k));
        end
        @(negedge clk); #0.5;
        check("R6 drained quiet", 32'(ch_wstb), 32'h0);

        // R6: direct send wins the bus over a drain in the same cycle
        ch_busy = 5'b00100;
        host_write(8'hA0, 32'h5555_0002);
        check("R6 queued one", host_rd_data, 32'h0000_0001);
        @(negedge clk);
        ch_busy = '0;
        host_wr_en = 1'b1; host_wr_addr = 8'hA4; host_wr_data = 32'h7777_0003;
        @(negedge clk);
        host_wr_en = 1'b0; #0.5;
        check("R6 direct first", 32'(ch_wstb), 32'h8);
        check("R6 direct data", ch_wdata, 32'h7777_0003);
        @(negedge clk); #0.5;
        check("R6 queued next", 32'(ch_wstb), 32'h4);
        check("R6 queued data", ch_wdata, 32'h5555_0002);

        // R8 / R9: gather responses in ascending order, stop when full
        @(negedge clk);
        for (int c = 0; c < N; c++) ch_rdata[c*32 +: 32] = rsp_of(c);
        ch_avail = '1;
        #1;
        pend = ch_rack;
        check("R8 first ack", 32'(pend), 32'h1);
        for (int k = 0; k < 8; k++) resp_cycle();
        check("R9 left pending", 32'(ch_avail), 32'h10);
        check("R9 no ack when full", 32'(ch_rack), 32'h0);
        for (int k = 0; k < N; k++) begin
            check("R8 in_empty", 32'(in_empty), 32'h0);
            check("R8 order", in_data, rsp_of(k));
            in_pop = 1'b1;
            resp_cycle();
            in_pop = 1'b0;
        end
        resp_cycle();
        check("R8 drained", 32'(in_empty), 32'h1);

        // R10: invalid marker acknowledged, not stored, error pulse
        @(negedge clk);
        ch_rdata[1*32 +: 32] = INV;
        ch_avail = 5'b00010;
        #1;
        pend = ch_rack;
        check("R10 ack", 32'(pend), 32'h2);
        resp_cycle();
        check("R10 err", 32'(err), 32'h1);
        check("R10 not stored", 32'(in_empty), 32'h1);
        resp_cycle();
        check("R10 R11 pulse end", 32'(err), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule